// File: doc/BRIEF.md
# Frame Transmit Sequencer with Buffer Credit Gating

This block builds the 32-bit transmit word stream of a serial storage link port. It emits exactly one word per clock on `tx_word`, with `tx_k` set when the most significant byte lane (bits 31:24) carries a special character. A frame is sent as a start delimiter, then the header and payload words taken from a valid/ready stream, then a computed CRC-32 word, then an end delimiter. Between frames the block sends fill words. When a local receive buffer is released it also sends a receiver-ready primitive.

A frame starts only while the link is active and at least one buffer-to-buffer credit is held. Each start delimiter uses up one credit. Each receiver-ready primitive that the peer returns gives one credit back, and the count never rises above the login value `LOGIN_CREDIT`. Local buffer releases are counted. Each one becomes one receiver-ready primitive, and these are sent only between frames. When both are waiting, a primitive goes out before a frame.

The controller has seven states:
- `ST_FILL` sends a fill word.
- `ST_RRDY` sends a receiver-ready primitive.
- `ST_SOF` sends the start delimiter.
- `ST_DATA` sends the last word accepted from the stream.
- `ST_GAP` sends a fill word while the source stalls inside a frame.
- `ST_CRC` sends the CRC word.
- `ST_EOF` sends the end delimiter.

The transitions are:
- From `ST_FILL` or `ST_RRDY`: to `ST_RRDY` if a primitive is pending, otherwise to `ST_SOF` if a frame is offered and credit is held, otherwise to `ST_FILL`. None of these moves is taken while the link is down.
- From `ST_SOF` or `ST_GAP`: to `ST_DATA` on a handshake, otherwise to `ST_GAP`.
- From `ST_DATA`: to `ST_CRC` after the word marked last, otherwise to `ST_DATA` on a handshake and to `ST_GAP` without one.
- `ST_CRC` always moves to `ST_EOF`, and `ST_EOF` always moves to `ST_FILL`.

Top module: `frame_tx_sequencer`

## Requirements
- R1: After reset the output is the fill word 32'hBC95B5B5 with `tx_k`=1 and `in_ready`=0. The credit count starts at `LOGIN_CREDIT` and no primitive is pending.
- R2: A frame begins with the start delimiter 32'hBCB55757 (`tx_k`=1). The accepted stream words follow in order, one per handshake, each with `tx_k`=0.
- R3: The word after the last stream word is the bitwise inverse of the CRC-32, sent with `tx_k`=0. The CRC uses polynomial 32'h04C11DB7, starts from all ones, takes each word most significant bit first, and covers every accepted word of the frame. The end delimiter 32'hBC95D5D5 (`tx_k`=1) follows.
- R4: At least one fill word 32'hBC95B5B5 (`tx_k`=1) follows every end delimiter. A fill word is sent in every cycle that carries no frame word or primitive.
- R5: A frame starts only when the credit count is non-zero, and each start delimiter uses one credit. With zero credit an offered frame waits and only fill words are sent.
- R6: Each one-cycle pulse on `peer_rrdy` returns one credit. The count saturates at `LOGIN_CREDIT`, and pulses beyond that are lost.
- R7: Each one-cycle pulse on `rxbuf_freed` produces exactly one receiver-ready primitive 32'hBC954A4A with `tx_k`=1.
- R8: A receiver-ready primitive is never sent between a start delimiter and its end delimiter.
- R9: A pending receiver-ready primitive is sent before a frame that is waiting at the same time.
- R10: While `link_up` is 0, only fill words are sent and `in_ready` stays 0. Pending primitives and offered frames go out once `link_up` returns to 1.
- R11: `in_ready` is 1 only in the start-delimiter cycle and in frame-body cycles before the last word has been taken. A stream stall inside a frame produces fill words and does not change the CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link is in its active state |
| in_valid | input | 1 | Stream word offered |
| in_data | input | 32 | Header or payload word |
| in_last | input | 1 | Offered word is the last of its frame |
| in_ready | output | 1 | Stream word accepted this cycle when `in_valid` is also 1 |
| peer_rrdy | input | 1 | Pulse: peer returned one buffer credit |
| rxbuf_freed | input | 1 | Pulse: a local receive buffer is free again |
| tx_word | output | 32 | Transmit word |
| tx_k | output | 1 | Upper byte lane of `tx_word` is a special character |

## Verification
The hardest case to reach is a frame offered while the credit count is already zero. The stimulus uses up the login credits with complete frames, then raises `in_valid` with no credit left and watches only fill words go out until a single `peer_rrdy` pulse releases the frame. Saturation is reached by pulsing `peer_rrdy` more times than the login value from an empty count, then showing that only `LOGIN_CREDIT` frames pass before the next one waits. Release pulses are issued during a frame's payload, so that the queued primitives have to wait for the end delimiter.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

    localparam logic [31:0] FILL_WORD = 32'hBC95B5B5;
    localparam logic [31:0] RRDY_WORD = 32'hBC954A4A;
    localparam logic [31:0] SOF_WORD  = 32'hBCB55757;
    localparam logic [31:0] EOF_WORD  = 32'hBC95D5D5;
    localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_RRDY,
        ST_SOF,
        ST_DATA,
        ST_GAP,
        ST_CRC,
        ST_EOF
    } ftx_state_e;

    // One 32-bit word folded into the CRC, most significant bit first.
    function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [31:0] d);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int i = 31; i >= 0; i--) begin
            fb = c[31] ^ d[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/ftx_sat_cnt.sv
module ftx_sat_cnt #(
    parameter int MAXV  = 2,
    parameter int INITV = 0,
    localparam int W    = $clog2(MAXV + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= W'(INITV);
        end else if (inc && !dec) begin
            if (cnt < W'(MAXV)) cnt <= cnt + W'(1);
        end else if (dec && !inc) begin
            if (cnt != '0) cnt <= cnt - W'(1);
        end
    end

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> cnt != '0);

    // R6
    ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= W'(MAXV));

endmodule

// File: rtl/ftx_crc.sv
module ftx_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [31:0] data,
    output logic [31:0] crc
);
    import ftx_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc <= '1;
        else if (en)       crc <= crc_step(crc, data);
    end

    // R11
    crc_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> crc == $past(crc));

endmodule

// File: rtl/frame_tx_sequencer.sv
module frame_tx_sequencer #(
    parameter int LOGIN_CREDIT   = 2,
    parameter int RRDY_QUEUE_MAX = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_up,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    input  logic        in_last,
    output logic        in_ready,
    input  logic        peer_rrdy,
    input  logic        rxbuf_freed,
    output logic [31:0] tx_word,
    output logic        tx_k
);
    import ftx_pkg::*;

    localparam int CRD_W  = $clog2(LOGIN_CREDIT + 1);
    localparam int PEND_W = $clog2(RRDY_QUEUE_MAX + 1);

    ftx_state_e          state_q, state_d;
    logic [31:0]         data_q;
    logic                last_q;
    logic [31:0]         crc_q;
    logic [CRD_W-1:0]    credit_cnt;
    logic [PEND_W-1:0]   pend_cnt;
    logic                in_frame, accept, rrdy_more, between;

    assign between  = (state_q == ST_FILL) || (state_q == ST_RRDY);
    assign in_frame = !between;
    assign in_ready = (state_q == ST_SOF) ||
                      (((state_q == ST_DATA) || (state_q == ST_GAP)) && !last_q);
    assign accept   = in_valid && in_ready;
    // In the primitive cycle the counter has not yet dropped by one.
    assign rrdy_more = (state_q == ST_RRDY) ? (pend_cnt > PEND_W'(1)) : (pend_cnt != '0);

    ftx_sat_cnt #(.MAXV(LOGIN_CREDIT), .INITV(LOGIN_CREDIT)) credit_i (
        .clk(clk), .rst_n(rst_n),
        .inc(peer_rrdy), .dec(state_q == ST_SOF),
        .cnt(credit_cnt)
    );

    ftx_sat_cnt #(.MAXV(RRDY_QUEUE_MAX), .INITV(0)) pend_i (
        .clk(clk), .rst_n(rst_n),
        .inc(rxbuf_freed), .dec(state_q == ST_RRDY),
        .cnt(pend_cnt)
    );

    ftx_crc crc_i (
        .clk(clk), .rst_n(rst_n),
        .clr(between), .en(accept), .data(in_data),
        .crc(crc_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            last_q <= 1'b0;
        end else if (accept) begin
            data_q <= in_data;
            last_q <= in_last;
        end else if (!in_frame) begin
            last_q <= 1'b0;
        end
    end

    always_comb begin
        state_d = ST_FILL;
        unique case (state_q)
            ST_FILL, ST_RRDY: begin
                if (link_up && rrdy_more)                         state_d = ST_RRDY;
                else if (link_up && in_valid && credit_cnt != '0) state_d = ST_SOF;
                else                                              state_d = ST_FILL;
            end
            ST_SOF, ST_GAP: state_d = accept ? ST_DATA : ST_GAP;
            ST_DATA: begin
                if (last_q)      state_d = ST_CRC;
                else if (accept) state_d = ST_DATA;
                else             state_d = ST_GAP;
            end
            ST_CRC:  state_d = ST_EOF;
            ST_EOF:  state_d = ST_FILL;
            default: state_d = ST_FILL;
        endcase
    end

    always_comb begin
        tx_word = FILL_WORD;
        tx_k    = 1'b1;
        unique case (state_q)
            ST_FILL: begin tx_word = FILL_WORD; tx_k = 1'b1; end
            ST_RRDY: begin tx_word = RRDY_WORD; tx_k = 1'b1; end
            ST_SOF:  begin tx_word = SOF_WORD;  tx_k = 1'b1; end
            ST_DATA: begin tx_word = data_q;    tx_k = 1'b0; end
            ST_GAP:  begin tx_word = FILL_WORD; tx_k = 1'b1; end
            ST_CRC:  begin tx_word = ~crc_q;    tx_k = 1'b0; end
            ST_EOF:  begin tx_word = EOF_WORD;  tx_k = 1'b1; end
            default: begin tx_word = FILL_WORD; tx_k = 1'b1; end
        endcase
    end

    // R3
    crc_then_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_CRC |=> (state_q == ST_EOF && tx_word == EOF_WORD));

    // R4
    eof_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_EOF |=> (tx_word == FILL_WORD && tx_k));

    // R8
    rrdy_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RRDY |=> (state_q == ST_FILL || state_q == ST_RRDY || state_q == ST_SOF));

    // R10
    link_down_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && between) |=> (state_q == ST_FILL && tx_word == FILL_WORD));

    // R11
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> in_frame);

endmodule

// File: tb/frame_tx_sequencer_tb.sv
`timescale 1ns/1ps
module frame_tx_sequencer_tb_top;

    localparam logic [31:0] W_FILL = 32'hBC95B5B5;
    localparam logic [31:0] W_RRDY = 32'hBC954A4A;
    localparam logic [31:0] W_SOF  = 32'hBCB55757;
    localparam logic [31:0] W_EOF  = 32'hBC95D5D5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        peer_rrdy = 1'b0;
    logic        rxbuf_freed = 1'b0;
    logic [31:0] tx_word;
    logic        tx_k;

    frame_tx_sequencer #(.LOGIN_CREDIT(2), .RRDY_QUEUE_MAX(15)) dut_i (
        .clk(clk), .rst_n(rst_n), .link_up(link_up),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .peer_rrdy(peer_rrdy), .rxbuf_freed(rxbuf_freed),
        .tx_word(tx_word), .tx_k(tx_k)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    logic [32:0] tr [0:255];
    int tn = 0;
    logic [31:0] src [0:15];
    int src_n = 0, src_idx = 0, gap_at = -1, gap_left = 0;
    bit src_go = 0, hs_prev = 0, p_rrdy = 0, p_free = 0;

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (hs_prev) src_idx++;
        peer_rrdy   = p_rrdy;
        rxbuf_freed = p_free;
        p_rrdy = 0;
        p_free = 0;
        if (src_go && src_idx < src_n) begin
            if (src_idx == gap_at && gap_left > 0) begin
                in_valid = 1'b0;
                gap_left--;
            end else begin
                in_valid = 1'b1;
                in_data  = src[src_idx];
                in_last  = (src_idx == src_n - 1);
            end
        end else begin
            in_valid = 1'b0;
            in_last  = 1'b0;
            src_go   = 0;
        end
        if (tn < 256) begin
            tr[tn] = {tx_k, tx_word};
            tn++;
        end
        hs_prev = in_valid && in_ready;
    endtask

    task automatic run(input int n);
        repeat (n) step();
    endtask

    task automatic load(input int n, input int tag);
        for (int i = 0; i < n; i++) src[i] = {8'(8'h20 + tag), 8'h6E, 8'(i), 8'(8'h11 * (i + 1))};
        src_n = n;
        src_idx = 0;
        hs_prev = 0;
        src_go = 1;
    endtask

    function automatic int find(input logic [32:0] w);
        for (int i = 0; i < tn; i++) if (tr[i] == w) return i;
        return -1;
    endfunction

    function automatic int count(input logic [32:0] w);
        int c = 0;
        for (int i = 0; i < tn; i++) if (tr[i] == w) c++;
        return c;
    endfunction

    function automatic logic [31:0] crc_ref(input int n);
        logic [31:0] c = '1;
        for (int k = 0; k < n; k++)
            for (int b = 31; b >= 0; b--) begin
                logic fb = c[31] ^ src[k][b];
                c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
            end
        return ~c;
    endfunction

    // Contiguous frame starting at trace index s: checks R2, R3 and R4.
    task automatic check_frame(input string tag, input int s);
        if (s < 0 || s + src_n + 3 >= tn) begin
            checks++;
            failures++;
            $display("FAIL %s R2 frame start actual=%0d expected=found", tag, s);
            return;
        end
        chk({tag, " R2 sof"}, tr[s], {1'b1, W_SOF});
        for (int i = 0; i < src_n; i++) chk({tag, " R2 word"}, tr[s + 1 + i], {1'b0, src[i]});
        chk({tag, " R3 crc"}, tr[s + 1 + src_n], {1'b0, crc_ref(src_n)});
        chk({tag, " R3 eof"}, tr[s + 2 + src_n], {1'b1, W_EOF});
        chk({tag, " R4 fill after eof"}, tr[s + 3 + src_n], {1'b1, W_FILL});
    endtask

    task automatic t_reset();
        chk("R1 reset word", {tx_k, tx_word}, {1'b1, W_FILL});
        chk("R1 reset ready", 33'(in_ready), 33'(0));
    endtask

    task automatic t_basic();
        load(7, 1); tn = 0; run(25);
        check_frame("basic", find({1'b1, W_SOF}));
    endtask

    task automatic t_credit_block();
        load(5, 2); tn = 0; run(20);
        check_frame("second", find({1'b1, W_SOF}));
        load(5, 3); tn = 0; run(30);
        chk("R5 held without credit", 33'(find({1'b1, W_SOF})), 33'(-1));
        chk("R5 only fill", 33'(count({1'b1, W_FILL})), 33'(tn));
        p_rrdy = 1; tn = 0; run(25);
        check_frame("R6 released", find({1'b1, W_SOF}));
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 4; i++) begin p_rrdy = 1; step(); end
        run(2);
        load(4, 4); tn = 0; run(20); check_frame("R6 sat a", find({1'b1, W_SOF}));
        load(4, 5); tn = 0; run(20); check_frame("R6 sat b", find({1'b1, W_SOF}));
        load(4, 6); tn = 0; run(30);
        chk("R6 saturated at login", 33'(find({1'b1, W_SOF})), 33'(-1));
        p_rrdy = 1; tn = 0; run(25);
        check_frame("R6 sat c", find({1'b1, W_SOF}));
    endtask

    task automatic t_rrdy_in_frame();
        int s, e, r;
        p_rrdy = 1; step(); p_rrdy = 1; step();
        load(8, 7); tn = 0; run(3);
        p_free = 1; step(); p_free = 1; step();
        run(25);
        s = find({1'b1, W_SOF});
        e = find({1'b1, W_EOF});
        r = find({1'b1, W_RRDY});
        check_frame("R8 frame", s);
        chk("R7 two primitives", 33'(count({1'b1, W_RRDY})), 33'(2));
        chk("R8 primitive after eof", 33'(r > e && e > s), 33'(1));
    endtask

    task automatic t_priority();
        int s, r;
        p_free = 1; step();
        load(4, 8); tn = 0; run(25);
        s = find({1'b1, W_SOF});
        r = find({1'b1, W_RRDY});
        chk("R9 primitive before frame", 33'(r >= 0 && r < s), 33'(1));
        check_frame("R9 frame", s);
    endtask

    task automatic t_link_down();
        int s, r;
        p_rrdy = 1; step();
        link_up = 1'b0;
        p_free = 1; step();
        load(3, 9); tn = 0; run(20);
        chk("R10 only fill while down", 33'(count({1'b1, W_FILL})), 33'(tn));
        link_up = 1'b1; tn = 0; run(25);
        s = find({1'b1, W_SOF});
        r = find({1'b1, W_RRDY});
        chk("R10 resume primitive", 33'(r >= 0 && r < s), 33'(1));
        check_frame("R10 frame", s);
    endtask

    task automatic t_stall();
        int s;
        p_rrdy = 1; step();
        load(5, 10); gap_at = 3; gap_left = 2; tn = 0; run(25);
        gap_at = -1;
        s = find({1'b1, W_SOF});
        if (s < 0) begin
            checks++; failures++;
            $display("FAIL R11 stall frame actual=-1 expected=found");
            return;
        end
        for (int i = 0; i < 3; i++) chk("R11 pre-stall word", tr[s + 1 + i], {1'b0, src[i]});
        chk("R11 stall fill 1", tr[s + 4], {1'b1, W_FILL});
        chk("R11 stall fill 2", tr[s + 5], {1'b1, W_FILL});
        chk("R11 post-stall word", tr[s + 6], {1'b0, src[3]});
        chk("R11 last word", tr[s + 7], {1'b0, src[4]});
        chk("R11 crc unaffected", tr[s + 8], {1'b0, crc_ref(5)});
        chk("R11 eof", tr[s + 9], {1'b1, W_EOF});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_credit_block();
        t_saturate();
        t_rrdy_in_frame();
        t_priority();
        t_link_down();
        t_stall();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule